// File: doc/BRIEF.md
# SD Card Clock Divider Controller

This block derives the SD card bus clock from the host clock. Software picks a power-of-two division ratio by writing a one-hot code into a card-clock control register, and a separate mode bit either uses that divided clock or passes the host clock straight through at full rate. The clock reaches the card only while two independent gate bits are both set: the enable bit in the card-clock register and the run bit in a separate gate register. Software starts the clock by setting the enable bit and then the gate bit. It stops the clock by clearing the gate bit and then the enable bit.

A new ratio, a new mode or a start/stop request is never applied mid-pulse. The block holds the request until the outgoing SD clock is in a low phase at a half-period boundary, and only then moves to the new setting. The output therefore never carries a shortened high pulse. A status output reports whether the clock is currently running.

Register select values are 0 for card-clock control, 1 for clock mode, 2 for the gate, and 3 for an unused slot. Writes take effect on the rising host-clock edge where `reg_we` is high. Reads are combinational from `reg_sel`.

Top module: `sdclk_divctl`

## Requirements
- R1: After reset the SD clock output is low and `clk_running` is 0. The card-clock register reads 0x0001: code bit 0 is set, which is the slowest ratio, and the enable bit (bit 8) is clear. The mode register reads 1 (divided). The gate register reads 0.
- R2: Register layout. At select 0, bits [7:0] are the divider code and bit 8 is the enable. At select 1, bit 0 is the mode. At select 2, bit 8 is the gate. Every other bit reads 0, and select 3 reads 0 and ignores writes.
- R3: The SD clock runs only while the enable bit and the gate bit are both 1. With either bit clear, the output stays low once it has stopped.
- R4: With divided mode and exactly code bit i set, the SD clock period is 2^(9-i) host cycles, with equal high and low halves. Bit 7 gives /4 and bit 0 gives /512.
- R5: A divider code with no bit set, or with more than one bit set, gives the slowest ratio, /512.
- R6: With the mode bit at 0 and the clock running, the output follows the host clock: high during the host high phase and low during the host low phase.
- R7: Changes to the ratio, the mode or the run state take effect only when the divided clock is low at the end of a half period. Every high pulse of the divided clock lasts exactly the half period that was active when it began.
- R8: `clk_running` is 1 exactly while the block is generating a clock, in either mode. It changes at the same boundary where the new setting takes effect.
- R9: After the gate bit is cleared, the output reaches low and `clk_running` drops within one period of the current ratio. A later restart begins with a full low half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock, source of the SD clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 card-clock, 1 mode, 2 gate, 3 unused) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_sel` |
| card_clk | output | 1 | Gated SD card clock |
| clk_running | output | 1 | High while the SD clock is being generated |

## Verification
The properties take for granted that reset is held low for at least one host edge before any write. They also assume `reg_we`, `reg_sel` and `reg_wdata` are changed only away from the rising host edge, so each write is seen whole at exactly one edge. The properties do not rely on software keeping to the start and stop order: the boundary rule must hold for any interleaving of enable, gate, mode and code writes. The stimulus drives every write on the falling edge. It covers both gate orders, switches the ratio and the mode while the clock is running, and uses codes with zero bits and with two bits set, so the boundary logic is exercised from each starting state.

// File: rtl/sdclk_pkg.sv
// Shared definitions for the SD clock divider controller.
// Assumes: a two-bit register select; bit positions here are decoded by
// both the register file and the bench.
package sdclk_pkg;

    // Register select codes on the simple register port.
    typedef enum logic [1:0] {
        SEL_CARDCLK = 2'd0,
        SEL_MODE    = 2'd1,
        SEL_GATE    = 2'd2,
        SEL_SPARE   = 2'd3
    } reg_sel_e;

    // Gate bit position inside the gate register.
    localparam int GATE_BIT = 8;

    // Mode bit position inside the mode register.
    localparam int MODE_BIT = 0;

endpackage

// File: rtl/sdclk_ratio_dec.sv
// Turns the one-hot divider code into a half-period length in host cycles.
// Code bit i selects half period 2^(CODE_W-i). An empty or multi-bit code
// falls back to the slowest half period, 2^CODE_W.
// Assumes: HALF_W = CODE_W + 1, so the slowest half period fits.
module sdclk_ratio_dec #(
    parameter int CODE_W = 8,
    parameter int HALF_W = CODE_W + 1
) (
    input  logic [CODE_W-1:0] code,
    output logic [HALF_W-1:0] half_len
);
    localparam logic [HALF_W-1:0] SLOW_HALF = HALF_W'(1) << CODE_W;
    localparam int CNT_W = $clog2(CODE_W + 1);

    logic [HALF_W-1:0] cand   [CODE_W];
    logic [HALF_W-1:0] picked;
    logic [CNT_W-1:0]  ones;

    // One candidate half period per code bit.
    for (genvar gi = 0; gi < CODE_W; gi++) begin : g_cand
        assign cand[gi] = HALF_W'(1) << (CODE_W - gi);
    end

    // Count the set bits and OR together the candidates they select.
    always_comb begin
        ones   = '0;
        picked = '0;
        for (int i = 0; i < CODE_W; i++) begin
            if (code[i]) begin
                ones   = ones + CNT_W'(1);
                picked = picked | cand[i];
            end
        end
    end

    // Fall back to the slowest ratio unless exactly one bit is set.
    always_comb begin
        half_len = (ones == CNT_W'(1)) ? picked : SLOW_HALF;
    end

endmodule

// File: rtl/sdclk_regs.sv
// Register file: divider code and enable, clock mode, gate bit.
// It produces the combined run request, the mode and the decoded half period.
// Assumes: writes are one-cycle strobes sampled on the rising host edge.
module sdclk_regs
    import sdclk_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int DATA_W = 16,
    parameter int HALF_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              run_req,
    output logic              div_mode,
    output logic [HALF_W-1:0] half_sel
);
    localparam logic [CODE_W-1:0] CODE_RST = CODE_W'(1);

    logic [CODE_W-1:0] code_q;
    logic              en_q;
    logic              mode_q;
    logic              gate_q;
    reg_sel_e          sel;

    assign sel = reg_sel_e'(reg_sel);

    // Register writes; the reset state is stopped, slowest ratio, divided mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_RST;
            en_q   <= 1'b0;
            mode_q <= 1'b1;
            gate_q <= 1'b0;
        end else if (reg_we) begin
            case (sel)
                SEL_CARDCLK: begin
                    code_q <= reg_wdata[CODE_W-1:0];
                    en_q   <= reg_wdata[CODE_W];
                end
                SEL_MODE: mode_q <= reg_wdata[MODE_BIT];
                SEL_GATE: gate_q <= reg_wdata[GATE_BIT];
                default: ;
            endcase
        end
    end

    // Read mux; bits without storage read as zero.
    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CARDCLK: begin
                reg_rdata[CODE_W-1:0] = code_q;
                reg_rdata[CODE_W]     = en_q;
            end
            SEL_MODE: reg_rdata[MODE_BIT] = mode_q;
            SEL_GATE: reg_rdata[GATE_BIT] = gate_q;
            default: ;
        endcase
    end

    // The clock may run only when both gate bits agree.
    assign run_req  = en_q & gate_q;
    assign div_mode = mode_q;

    sdclk_ratio_dec #(
        .CODE_W (CODE_W),
        .HALF_W (HALF_W)
    ) u_dec (
        .code     (code_q),
        .half_len (half_sel)
    );

endmodule

// File: rtl/sdclk_divcore.sv
// Divided-clock generator with boundary-only reconfiguration.
// The requested run state, mode and half period are copied into the active
// set only while the divided output is low and a half period has ended,
// while the clock is stopped, or while bypass is active.
// Assumes: half_sel is at least 1.
module sdclk_divcore #(
    parameter int CODE_W = 8,
    parameter int HALF_W = CODE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              div_mode,
    input  logic [HALF_W-1:0] half_sel,
    output logic              div_q,
    output logic              act_run,
    output logic              act_byp,
    output logic [HALF_W-1:0] act_half
);
    localparam logic [HALF_W-1:0] SLOW_HALF = HALF_W'(1) << CODE_W;

    logic [HALF_W-1:0] cnt_q;
    logic              at_end;
    logic              safe;
    logic              was_div;
    logic              want_div;

    // Boundary and state qualifiers for the update rule.
    always_comb begin
        at_end   = (cnt_q == act_half - HALF_W'(1));
        was_div  = act_run & ~act_byp;
        want_div = run_req & div_mode;
        safe     = ~div_q & (~act_run | act_byp | at_end);
    end

    // Divider counter, output toggle and active-configuration load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q    <= 1'b0;
            act_run  <= 1'b0;
            act_byp  <= 1'b0;
            act_half <= SLOW_HALF;
            cnt_q    <= '0;
        end else if (safe) begin
            act_run  <= run_req;
            act_byp  <= ~div_mode;
            act_half <= half_sel;
            cnt_q    <= '0;
            div_q    <= want_div & was_div;
        end else if (was_div) begin
            if (at_end) begin
                cnt_q <= '0;
                div_q <= ~div_q;
            end else begin
                cnt_q <= cnt_q + HALF_W'(1);
            end
        end
    end

endmodule

// File: rtl/sdclk_outgate.sv
// Output stage: merges the divided clock with a gated copy of the host clock.
// The bypass enable is retimed on the falling host edge, so the AND gate
// only opens or closes while the host clock is low.
// Assumes: div_q is low whenever bypass is active.
module sdclk_outgate (
    input  logic clk,
    input  logic rst_n,
    input  logic div_q,
    input  logic act_run,
    input  logic act_byp,
    output logic full_on,
    output logic card_clk
);
    // Retime the bypass enable into the host low phase.
    always_ff @(negedge clk) begin
        if (!rst_n) full_on <= 1'b0;
        else        full_on <= act_run & act_byp;
    end

    // Merge the divided and undivided sources.
    assign card_clk = div_q | (clk & full_on);

endmodule

// File: rtl/sdclk_divctl.sv
// Top level of the SD card clock divider controller.
// It joins the register file, the divider core and the output stage.
// Assumes: CODE_W < DATA_W and GATE_BIT < DATA_W.
module sdclk_divctl #(
    parameter int CODE_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_sel,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              card_clk,
    output logic              clk_running
);
    localparam int HALF_W = CODE_W + 1;

    logic              run_req;
    logic              div_mode;
    logic [HALF_W-1:0] half_sel;
    logic              div_q;
    logic              act_run;
    logic              act_byp;
    logic [HALF_W-1:0] act_half;
    logic              full_on;

    sdclk_regs #(
        .CODE_W (CODE_W),
        .DATA_W (DATA_W),
        .HALF_W (HALF_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .run_req   (run_req),
        .div_mode  (div_mode),
        .half_sel  (half_sel)
    );

    sdclk_divcore #(
        .CODE_W (CODE_W),
        .HALF_W (HALF_W)
    ) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_req  (run_req),
        .div_mode (div_mode),
        .half_sel (half_sel),
        .div_q    (div_q),
        .act_run  (act_run),
        .act_byp  (act_byp),
        .act_half (act_half)
    );

    sdclk_outgate u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_q    (div_q),
        .act_run  (act_run),
        .act_byp  (act_byp),
        .full_on  (full_on),
        .card_clk (card_clk)
    );

    assign clk_running = act_run;

endmodule

// File: rtl/sdclk_divctl_chk.sv
// Property checker for the SD clock divider controller, bound to the top.
// It measures each divided high pulse with its own counter and checks the
// start, stop and reset behaviour against the request.
module sdclk_divctl_chk #(
    parameter int HALF_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_req,
    input logic              div_q,
    input logic              full_on,
    input logic              clk_running,
    input logic [HALF_W-1:0] act_half
);
    logic [HALF_W:0] hi_cnt;
    logic            was_rst;

    // Length of the current high pulse, in host cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cnt <= '0;
        else if (div_q) hi_cnt <= hi_cnt + 1'b1;
        else            hi_cnt <= '0;
    end

    // Marks the first cycle after reset is released.
    always_ff @(posedge clk) begin
        was_rst <= ~rst_n;
    end

    // R7: each divided high pulse lasts exactly the active half period.
    assert_full_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(div_q) |-> (hi_cnt == {1'b0, act_half}));

    // R3: the clock starts only when both gate bits ask for it.
    assert_start_needs_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_running) |-> $past(run_req));

    // R9: the clock stops only from a low divided phase.
    assert_stop_from_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_running) |-> !$past(div_q));

    // R6: the bypass path and the divided path are never on together.
    assert_bypass_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        full_on |-> !div_q);

    // R1: leaving reset, the clock is stopped and low.
    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        was_rst |-> (!clk_running && !div_q && !full_on));

endmodule

bind sdclk_divctl sdclk_divctl_chk #(
    .HALF_W (CODE_W + 1)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_req     (run_req),
    .div_q       (div_q),
    .full_on     (full_on),
    .clk_running (clk_running),
    .act_half    (act_half)
);

// File: tb/sim_sdclk_divctl.sv
// Bench for the SD clock divider controller. A behavioural model steps on
// every host edge and is compared with the outputs in both clock phases.
module sim_sdclk_divctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        card_clk;
    logic        clk_running;

    int checks = 0;
    int errors = 0;
    bit chk_on = 0;
    string phase = "R1";

    // Model state.
    int m_code = 1;
    bit m_en = 0, m_mode = 1, m_gate = 0;
    bit m_run = 0, m_byp = 0, m_div = 0, m_full = 0;
    int m_half = 256, m_cnt = 0;

    // Period measurement from the high-phase samples.
    int cyc = 0, last_rise = -1, last_period = 0;
    bit prev_hi = 0;

    always #5 clk = ~clk;

    sdclk_divctl u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_sel     (reg_sel),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .card_clk    (card_clk),
        .clk_running (clk_running)
    );

    // Half period from the code: a single set bit i gives 2^(8-i), else 256.
    function automatic int half_of(int code);
        int n = 0, h = 256;
        for (int i = 0; i < 8; i++) begin
            if (code[i]) begin
                n++;
                h = 1 << (8 - i);
            end
        end
        return (n == 1) ? h : 256;
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Model step on each rising edge: one state transition, then any write.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_code = 1; m_en = 0; m_mode = 1; m_gate = 0;
            m_run = 0; m_byp = 0; m_div = 0; m_half = 256; m_cnt = 0;
        end else begin
            bit low_edge, divided_before;
            low_edge = !m_div && (!m_run || m_byp || m_cnt == m_half - 1);
            divided_before = m_run && !m_byp;
            if (low_edge) begin
                m_div  = (m_en && m_gate && m_mode && divided_before);
                m_run  = m_en && m_gate;
                m_byp  = !m_mode;
                m_half = half_of(m_code);
                m_cnt  = 0;
            end else if (divided_before) begin
                if (m_cnt == m_half - 1) begin
                    m_cnt = 0;
                    m_div = !m_div;
                end else begin
                    m_cnt++;
                end
            end
            if (reg_we) begin
                case (reg_sel)
                    2'd0: begin m_code = reg_wdata[7:0]; m_en = reg_wdata[8]; end
                    2'd1: m_mode = reg_wdata[0];
                    2'd2: m_gate = reg_wdata[8];
                    default: ;
                endcase
            end
        end
    end

    // The bypass gate follows the run and bypass state on the falling edge.
    always @(negedge clk) m_full = rst_n ? (m_run && m_byp) : 1'b0;

    // Compare with the model in the high and the low phase of every cycle.
    initial forever begin
        @(posedge clk);
        #2;
        cyc++;
        if (chk_on) begin
            check(phase, card_clk, m_div | m_full, "card_clk high phase");
            check("R8", clk_running, m_run, "clk_running");
            if (card_clk && !prev_hi) begin
                if (last_rise >= 0) last_period = cyc - last_rise;
                last_rise = cyc;
            end
            prev_hi = card_clk;
        end
        @(negedge clk);
        #2;
        if (chk_on) check(phase, card_clk, m_div, "card_clk low phase");
    end

    task automatic wr(int sel, int data);
        @(negedge clk);
        reg_we = 1'b1;
        reg_sel = sel[1:0];
        reg_wdata = data[15:0];
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(string req, int sel, int exp);
        @(negedge clk);
        reg_sel = sel[1:0];
        #1;
        check(req, reg_rdata, exp, $sformatf("readback sel %0d", sel));
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R3 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(4);
        @(negedge clk);
        rst_n = 1'b1;
        chk_on = 1;
        // R1: reset state.
        check("R1", card_clk, 0, "card_clk after reset");
        check("R1", clk_running, 0, "clk_running after reset");
        rd("R1", 0, 16'h0001);
        rd("R1", 1, 16'h0001);
        rd("R1", 2, 16'h0000);

        // R3: enable alone does not start the clock.
        phase = "R3";
        wr(0, 16'h0180);
        idle(20);
        check("R3", clk_running, 0, "enable without gate");

        // R4: divide by 4.
        phase = "R4";
        wr(2, 16'h0100);
        idle(40);
        check("R8", clk_running, 1, "running after start");
        check("R4", last_period, 4, "period code bit 7");

        // R7: ratio change while running, to divide by 32.
        phase = "R7";
        wr(0, 16'h0110);
        idle(120);
        check("R4", last_period, 32, "period code bit 4");

        // R5: empty code, then a two-bit code.
        phase = "R5";
        wr(0, 16'h0100);
        idle(1100);
        check("R5", last_period, 512, "period empty code");
        wr(0, 16'h0106);
        idle(1100);
        check("R5", last_period, 512, "period two-bit code");

        // R7: back to divide by 8; the change waits for a low boundary.
        phase = "R7";
        wr(0, 16'h0140);
        idle(700);
        check("R4", last_period, 8, "period code bit 6");

        // R6: full-rate passthrough.
        phase = "R6";
        wr(1, 16'h0000);
        idle(20);
        @(posedge clk); #3;
        check("R6", card_clk, 1, "passthrough high phase");
        @(negedge clk); #3;
        check("R6", card_clk, 0, "passthrough low phase");
        check("R8", clk_running, 1, "running in passthrough");
        phase = "R7";
        wr(1, 16'h0001);
        idle(60);
        check("R4", last_period, 8, "period after leaving passthrough");

        // R9: stop order, gate first and then enable.
        phase = "R9";
        wr(2, 16'h0000);
        idle(20);
        check("R9", clk_running, 0, "stopped after gate clear");
        check("R9", card_clk, 0, "output low after stop");
        wr(0, 16'h0040);
        rd("R9", 0, 16'h0040);
        idle(10);
        check("R9", clk_running, 0, "still stopped");

        // R2: unused bits and the spare select.
        phase = "R2";
        wr(0, 16'hFE40);
        rd("R2", 0, 16'h0040);
        wr(2, 16'hFEFF);
        rd("R2", 2, 16'h0000);
        wr(2, 16'hFFFF);
        rd("R2", 2, 16'h0100);
        wr(1, 16'hFFFE);
        rd("R2", 1, 16'h0000);
        wr(1, 16'h0001);
        wr(3, 16'hFFFF);
        rd("R2", 3, 16'h0000);
        rd("R2", 0, 16'h0040);
        rd("R2", 1, 16'h0001);
        idle(10);
        check("R3", clk_running, 0, "gate set with enable clear");

        // R9: restart begins with a full low half period, then divides by 8.
        phase = "R9";
        wr(0, 16'h0140);
        idle(60);
        check("R9", last_period, 8, "period after restart");
        idle(4);

        chk_on = 0;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule